// File: doc/BRIEF.md
# USB Host Port Bus-Reset and Microframe Timer

This block holds the per-port enable and reset logic of an embedded USB 2.0 host controller, together with the free-running microframe timebase. A device-attach input and a speed-result input stand in for the line-state and chirp logic. Software sees a small port status view and an interrupt control view, both written through one register write strobe with a select bit.

Software starts a bus reset with one write. The block times the reset itself by counting microframe ticks and ignores any attempt to end it early. When the reset finishes, the block enables the port, latches the negotiated speed and flags an enable change. If the device detaches during the reset, the reset is abandoned. The microframe timer produces a one-cycle pulse every 125 us from the transceiver clock. That pulse also sets a start-of-frame flag that can raise the interrupt.

Top module: `usbp_port_reset_ctl`

## Requirements
- R1: After a synchronous reset, the port status view, the interrupt control view, the interrupt output and the tick output all read 0.
- R2: The tick output is a one-cycle pulse. Its period is PERIOD_NARROW cycles (default 7500, 60 MHz clock) when phy_wide_i is 0, and PERIOD_WIDE cycles (default 3750, 30 MHz clock) when phy_wide_i is 1.
- R3: Port status bit 0 follows dev_attach_i one cycle late. Every change of dev_attach_i sets the connect-change flag in bit 1.
- R4: Writing status (reg_sel_i=0) with bit 4 set starts a bus reset, but only while the device is attached and no reset is running. Bit 4 then reads 1 and the enable bit 2 reads 0.
- R5: The reset ends in the cycle after the RESET_TICKS-th tick (default 80) that follows the start write. Bit 4 then clears, and bits 2 and 3 (enable-change) set.
- R6: A status write with bit 4 at 0 during a reset has no effect on the reset.
- R7: A detach during a reset aborts it. Bits 4 and 2 clear, bit 1 sets, and bit 3 does not set.
- R8: Bits 1 and 3 of the status view, and bit 2 of the interrupt control view (the start-of-frame flag, set by each tick), are cleared by writing 1. A hardware set in the same cycle wins over the clear.
- R9: irq_o is registered. It is 1 one cycle after (control bit 0 AND (status bit 1 OR bit 3)) OR (control bit 1 AND control bit 2) holds.
- R10: A reset-start write while the device is detached is ignored.
- R11: Status bits 6:5 hold speed_i as sampled at the end of a reset. They are read-only and change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_wide_i | input | 1 | 1 selects the 16-bit, 30 MHz physical interface period |
| dev_attach_i | input | 1 | Device present on the port |
| speed_i | input | 2 | Speed result from the negotiation logic |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects port status, 1 selects interrupt control |
| reg_wdata_i | input | 8 | Write data |
| portsc_o | output | 8 | Port status view: {0, speed, reset, enable-change, enable, connect-change, connected} |
| ictl_o | output | 3 | Interrupt control view: {sof flag, sof enable, port-change enable} |
| irq_o | output | 1 | Interrupt request |
| sof_tick_o | output | 1 | Microframe start pulse |

## Verification
The bus reset is run to completion with a premature write of 0 in the middle. This separates a hardware-timed reset from one that software could shorten. A second reset is cut short by a detach, which shows whether the abort path sets only the connect-change flag. A reset-start write while detached and a write to the speed field show that those writes are ignored. An attach edge that coincides with a clear of its own flag shows whether the set wins. The tick period is measured in both interface modes, and a cycle model in the bench follows every output on every clock.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  typedef enum logic [1:0] {
    PS_DETACHED = 2'd0,
    PS_IDLE     = 2'd1,
    PS_BUSRST   = 2'd2,
    PS_ACTIVE   = 2'd3
  } port_state_e;

  localparam int B_CONN  = 0;
  localparam int B_CCHG  = 1;
  localparam int B_EN    = 2;
  localparam int B_ECHG  = 3;
  localparam int B_RST   = 4;
  localparam int B_SPDLO = 5;
  localparam int B_SPDHI = 6;

  localparam int I_PCIE  = 0;
  localparam int I_SOFIE = 1;
  localparam int I_SOFF  = 2;
endpackage

// File: rtl/usbp_uframe_timer.sv
module usbp_uframe_timer #(
  parameter int unsigned PERIOD_NARROW = 7500,
  parameter int unsigned PERIOD_WIDE   = 3750
) (
  input  logic clk,
  input  logic rst,
  input  logic wide_i,
  output logic tick_o
);
  localparam int unsigned PMAX = (PERIOD_NARROW > PERIOD_WIDE) ? PERIOD_NARROW : PERIOD_WIDE;
  localparam int CW = $clog2(PMAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = wide_i ? CW'(PERIOD_WIDE - 1) : CW'(PERIOD_NARROW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R2: the microframe start is a single-cycle pulse
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/usbp_port_ctl.sv
module usbp_port_ctl
  import usbp_pkg::*;
#(
  parameter int unsigned RESET_TICKS = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       attach_i,
  input  logic [1:0] speed_i,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] portsc_o
);
  localparam int TW = $clog2(RESET_TICKS + 1);

  port_state_e st_q;
  logic          conn_q, cchg_q, echg_q;
  logic [TW-1:0] tcnt_q;
  logic [1:0]    spd_q;
  logic          start_req, rst_last;

  assign start_req = wr_i && wdata_i[B_RST] && attach_i &&
                     (st_q == PS_IDLE || st_q == PS_ACTIVE);
  assign rst_last  = tick_i && (tcnt_q == TW'(RESET_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_DETACHED;
      conn_q <= 1'b0;
      cchg_q <= 1'b0;
      echg_q <= 1'b0;
      tcnt_q <= '0;
      spd_q  <= 2'b00;
    end else begin
      conn_q <= attach_i;
      cchg_q <= (cchg_q & ~(wr_i & wdata_i[B_CCHG])) | (attach_i ^ conn_q);
      echg_q <= echg_q & ~(wr_i & wdata_i[B_ECHG]);
      if (!attach_i) begin
        st_q <= PS_DETACHED;
      end else begin
        case (st_q)
          PS_DETACHED: st_q <= PS_IDLE;
          PS_IDLE, PS_ACTIVE: begin
            if (start_req) begin
              st_q   <= PS_BUSRST;
              tcnt_q <= '0;
            end
          end
          PS_BUSRST: begin
            if (rst_last) begin
              st_q   <= PS_ACTIVE;
              echg_q <= 1'b1;
              spd_q  <= speed_i;
            end else if (tick_i) begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: st_q <= PS_DETACHED;
        endcase
      end
    end
  end

  assign portsc_o = {1'b0, spd_q, (st_q == PS_BUSRST), echg_q,
                     (st_q == PS_ACTIVE), cchg_q, conn_q};

  // R4: an accepted start shows reset and a disabled port
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (portsc_o[B_RST] && !portsc_o[B_EN]));
  // R6: a write of 0 cannot shorten a running reset
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_BUSRST && attach_i && !tick_i && wr_i && !wdata_i[B_RST]) |=> portsc_o[B_RST]);
  // R5: the last counted tick enables the port
  p_done_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_BUSRST && attach_i && rst_last) |=>
      (!portsc_o[B_RST] && portsc_o[B_EN] && portsc_o[B_ECHG]));
  // R7: a detach aborts the reset
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_BUSRST && !attach_i) |=>
      (!portsc_o[B_RST] && !portsc_o[B_EN] && portsc_o[B_CCHG]));
  // R10: no reset starts without a device
  p_nostart_r10: assert property (@(posedge clk) disable iff (rst)
    !attach_i |=> !portsc_o[B_RST]);
  // R11: speed changes only at the end of a reset
  p_speed_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_BUSRST) |=> $stable(portsc_o[B_SPDHI:B_SPDLO]));
endmodule

// File: rtl/usbp_irq_ctl.sv
module usbp_irq_ctl
  import usbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       port_chg_i,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic [2:0] ictl_o,
  output logic       irq_o
);
  logic pcie_q, sofie_q, soff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcie_q  <= 1'b0;
      sofie_q <= 1'b0;
      soff_q  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_i) begin
        pcie_q  <= wdata_i[I_PCIE];
        sofie_q <= wdata_i[I_SOFIE];
      end
      soff_q <= (soff_q & ~(wr_i & wdata_i[I_SOFF])) | tick_i;
      irq_o  <= (pcie_q & port_chg_i) | (sofie_q & soff_q);
    end
  end

  assign ictl_o = {soff_q, sofie_q, pcie_q};

  // R9: with both sources masked the request stays low
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!ictl_o[I_PCIE] && !ictl_o[I_SOFIE]) |=> !irq_o);
  // R8: a tick always leaves the frame flag set
  p_sofflag_r8: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> ictl_o[I_SOFF]);
endmodule

// File: rtl/usbp_port_reset_ctl.sv
module usbp_port_reset_ctl
  import usbp_pkg::*;
#(
  parameter int unsigned PERIOD_NARROW = 7500,
  parameter int unsigned PERIOD_WIDE   = 3750,
  parameter int unsigned RESET_TICKS   = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phy_wide_i,
  input  logic       dev_attach_i,
  input  logic [1:0] speed_i,
  input  logic       reg_wr_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] portsc_o,
  output logic [2:0] ictl_o,
  output logic       irq_o,
  output logic       sof_tick_o
);
  logic port_wr, ictl_wr, port_chg;

  assign port_wr  = reg_wr_i && !reg_sel_i;
  assign ictl_wr  = reg_wr_i && reg_sel_i;
  assign port_chg = portsc_o[B_CCHG] | portsc_o[B_ECHG];

  usbp_uframe_timer #(
    .PERIOD_NARROW(PERIOD_NARROW),
    .PERIOD_WIDE  (PERIOD_WIDE)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .wide_i(phy_wide_i),
    .tick_o(sof_tick_o)
  );

  usbp_port_ctl #(
    .RESET_TICKS(RESET_TICKS)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .attach_i(dev_attach_i),
    .speed_i (speed_i),
    .tick_i  (sof_tick_o),
    .wr_i    (port_wr),
    .wdata_i (reg_wdata_i),
    .portsc_o(portsc_o)
  );

  usbp_irq_ctl u_irq (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (sof_tick_o),
    .port_chg_i(port_chg),
    .wr_i      (ictl_wr),
    .wdata_i   (reg_wdata_i[2:0]),
    .ictl_o    (ictl_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/usbp_port_reset_ctl_tb_top.sv
`timescale 1ns/1ps
module usbp_port_reset_ctl_tb_top;
  localparam int PN = 24;
  localparam int PW = 12;
  localparam int RT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phy_wide_i = 1'b0;
  logic       dev_attach_i = 1'b0;
  logic [1:0] speed_i = 2'b00;
  logic       reg_wr_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] portsc_o;
  logic [2:0] ictl_o;
  logic       irq_o;
  logic       sof_tick_o;

  always #2.5 clk = ~clk;

  usbp_port_reset_ctl #(.PERIOD_NARROW(PN), .PERIOD_WIDE(PW), .RESET_TICKS(RT)) dut_i (
    .clk(clk), .rst(rst), .phy_wide_i(phy_wide_i), .dev_attach_i(dev_attach_i),
    .speed_i(speed_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .portsc_o(portsc_o), .ictl_o(ictl_o),
    .irq_o(irq_o), .sof_tick_o(sof_tick_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_tick = 0, m_conn = 0, m_csc = 0, m_pec = 0;
  int m_st = 0, m_tc = 0, m_spd = 0, m_pcie = 0, m_sofie = 0, m_soff = 0, m_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_conn = 0; m_csc = 0; m_pec = 0;
      m_st = 0; m_tc = 0; m_spd = 0; m_pcie = 0; m_sofie = 0; m_soff = 0; m_irq = 0;
    end else begin
      int lim, otick, nirq;
      bit wp, wi, att;
      lim = phy_wide_i ? PW : PN;
      wp = reg_wr_i && !reg_sel_i;
      wi = reg_wr_i && reg_sel_i;
      att = dev_attach_i;
      otick = m_tick;
      nirq = ((m_pcie != 0) && (m_csc != 0 || m_pec != 0)) || ((m_sofie != 0) && (m_soff != 0)) ? 1 : 0;
      m_csc = ((m_csc != 0 && !(wp && reg_wdata_i[1])) || (int'(att) != m_conn)) ? 1 : 0;
      m_conn = int'(att);
      if (wp && reg_wdata_i[3]) m_pec = 0;
      if (!att) m_st = 0;
      else if (m_st == 0) m_st = 1;
      else if (m_st == 1 || m_st == 3) begin
        if (wp && reg_wdata_i[4]) begin m_st = 2; m_tc = 0; end
      end else if (otick != 0) begin
        if (m_tc == RT - 1) begin m_st = 3; m_pec = 1; m_spd = int'(speed_i); end
        else m_tc++;
      end
      if (wi && reg_wdata_i[2]) m_soff = 0;
      if (otick != 0) m_soff = 1;
      if (wi) begin m_pcie = int'(reg_wdata_i[0]); m_sofie = int'(reg_wdata_i[1]); end
      m_irq = nirq;
      if (m_cnt >= lim - 1) begin m_cnt = 0; m_tick = 1; end
      else begin m_cnt++; m_tick = 0; end
    end
  end

  // compare every output against the model each cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 connected", int'(portsc_o[0]), m_conn);
      check("R3 connect-change", int'(portsc_o[1]), m_csc);
      check("R5 enable", int'(portsc_o[2]), (m_st == 3) ? 1 : 0);
      check("R5 enable-change", int'(portsc_o[3]), m_pec);
      check("R4 reset bit", int'(portsc_o[4]), (m_st == 2) ? 1 : 0);
      check("R11 speed", int'(portsc_o[6:5]), m_spd);
      check("R2 tick", int'(sof_tick_o), m_tick);
      check("R8 ictl", int'(ictl_o), m_soff * 4 + m_sofie * 2 + m_pcie);
      check("R9 irq", int'(irq_o), m_irq);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_wr(input bit sel, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic measure(input string req, input int exp);
    int n;
    while (!sof_tick_o) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!sof_tick_o);
    check(req, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 portsc", int'(portsc_o), 0);
    check("R1 ictl", int'(ictl_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 tick", int'(sof_tick_o), 0);
    measure("R2 narrow period", PN);
    do_wr(1'b1, 8'h01);
    do_wr(1'b0, 8'h10);
    check("R10 reset while detached", int'(portsc_o[4]), 0);
    dev_attach_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 attach flag", int'(portsc_o[1]), 1);
    check("R9 port irq", int'(irq_o), 1);
    do_wr(1'b0, 8'h02);
    speed_i = 2'd2;
    do_wr(1'b0, 8'h10);
    check("R4 reset started", int'(portsc_o[4]), 1);
    repeat (5) @(negedge clk);
    do_wr(1'b0, 8'h00);
    check("R6 write 0 ignored", int'(portsc_o[4]), 1);
    for (int i = 0; i < 400 && portsc_o[4]; i++) @(negedge clk);
    check("R5 enabled", int'(portsc_o[2]), 1);
    check("R5 enable-change", int'(portsc_o[3]), 1);
    check("R11 speed latched", int'(portsc_o[6:5]), 2);
    do_wr(1'b0, 8'h08);
    speed_i = 2'd1;
    do_wr(1'b0, 8'h60);
    check("R11 speed write ignored", int'(portsc_o[6:5]), 2);
    do_wr(1'b0, 8'h10);
    repeat (4) @(negedge clk);
    dev_attach_i = 1'b0;
    @(negedge clk);
    check("R7 reset aborted", int'(portsc_o[4]), 0);
    check("R7 disabled", int'(portsc_o[2]), 0);
    check("R7 connect-change", int'(portsc_o[1]), 1);
    check("R7 no enable-change", int'(portsc_o[3]), 0);
    do_wr(1'b0, 8'h02);
    dev_attach_i = 1'b1;
    do_wr(1'b0, 8'h02);
    check("R8 set wins over clear", int'(portsc_o[1]), 1);
    phy_wide_i = 1'b1;
    measure("R2 wide period first", PW);
    measure("R2 wide period", PW);
    do_wr(1'b1, 8'h06);
    while (!sof_tick_o) @(negedge clk);
    @(negedge clk);
    check("R8 sof flag set", int'(ictl_o[2]), 1);
    @(negedge clk);
    check("R9 sof irq", int'(irq_o), 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule